// File: doc/BRIEF.md
# Dual-Clock Stream FIFO

This block carries data words from a producer running on one clock to a consumer running on another clock. The two clocks have no fixed phase or frequency relation. Both sides are streaming interfaces with valid/ready handshakes. The producer holds `wr_valid` and `wr_data` until it sees `wr_ready` high at a `wclk` edge. The consumer finds the oldest stored word already on `rd_data` whenever `rd_valid` is high. It takes that word by raising `rd_ready`.

The words sit in a small register file. Each side keeps a position counter that has one more bit than the address needs. The extra bit records how many times the counter has wrapped. Each counter is passed to the other domain in reflected binary (Gray) form, through two flip-flops clocked by the receiving domain. The writer decides full against its delayed copy of the reader's counter. The reader decides empty against its delayed copy of the writer's counter. Both flags are registered. Because the copies lag the real counters, each flag can be held longer than needed, but neither is ever released too early.

Back-pressure works the same way on both sides:
- When `wr_ready` is low, the producer must hold its word.
- When `rd_ready` is low, the output word and `rd_valid` stay frozen.

Top module: `dc_stream_fifo`

## Requirements
- R1: While each side is in reset and after it leaves reset, the FIFO holds no words: `wr_ready` is 1 and `rd_valid` is 0.
- R2: A word is stored only at a `wclk` edge where `wr_valid` and `wr_ready` are both 1. A word is removed only at an `rclk` edge where `rd_valid` and `rd_ready` are both 1. No other cycle changes the contents.
- R3: The FIFO never holds more than DEPTH = 2^ADDR_W words. After DEPTH accepted writes with no reads, `wr_ready` is 0 in the following `wclk` cycle and stays 0 while nothing is read.
- R4: `rd_valid` is never 1 while the FIFO holds no words, so a read can never take a word that was not written.
- R5: Words leave in the order they were accepted, each exactly once, with no loss and no duplication.
- R6: The head word is shown without delay: whenever `rd_valid` is 1, `rd_data` equals the oldest stored word. While `rd_ready` is 0, `rd_valid` stays 1 and `rd_data` does not change.
- R7: Each position counter crosses domains in Gray code, so the crossing value changes in at most one bit per cycle of its source clock. It passes through two flip-flops in the destination clock.
- R8: Flags are released after a bounded delay. `rd_valid` rises within 6 `rclk` cycles after a word is written into an empty FIFO. `wr_ready` returns within 10 `wclk` cycles after a full FIFO is drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer-side clock |
| wrst_n | input | 1 | Producer-side asynchronous reset, active low |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ready | output | 1 | FIFO has room; the write happens when both are high |
| wr_data | input | DATA_W | Word offered by the producer |
| rclk | input | 1 | Consumer-side clock |
| rrst_n | input | 1 | Consumer-side asynchronous reset, active low |
| rd_valid | output | 1 | A stored word is present on `rd_data` |
| rd_ready | input | 1 | Consumer takes the head word when both are high |
| rd_data | output | DATA_W | Oldest stored word, shown without delay |

## Verification
The assertions check the following on every cycle:
- Each Gray counter changes in at most one bit per source-clock cycle.
- Neither side's view of the word count ever goes above DEPTH or below zero.
- A view showing DEPTH words forces `wr_ready` low, and a view showing zero words forces `rd_valid` low.
- The head word and `rd_valid` stay frozen under consumer stall.

Some behaviour only the bench scenarios can show, because it needs a model of the whole stream:
- that words leave in order, each exactly once, across unrelated clock rates and random stalls;
- that exactly DEPTH writes fit;
- that each flag is released within its delay bound.

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
// Two-stage flip-flop synchronizer for a Gray-coded counter bus.
module dcf_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dcf_regfile.sv
`timescale 1ns/1ps
// Storage array: written on the producer clock, read without a clock edge.
module dcf_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_ptr.sv
`timescale 1ns/1ps
// Wrap-tracking position counter, kept in both binary and Gray form.
module dcf_ptr #(
  parameter int ADDR_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  output logic [ADDR_W:0] bin,
  output logic [ADDR_W:0] bin_nx,
  output logic [ADDR_W:0] gray
);
  localparam int PW = ADDR_W + 1;

  assign bin_nx = bin + PW'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin  <= '0;
      gray <= '0;
    end else begin
      bin  <= bin_nx;
      gray <= bin_nx ^ (bin_nx >> 1);
    end
  end

  // R7: the value that crosses domains moves by at most one bit per cycle.
  p_gray_onebit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(gray ^ $past(gray)) <= 1));
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
// Producer-domain control: accepts writes, registers the full flag.
module dcf_wr_side #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W:0]   wptr_gray,
  input  logic [ADDR_W:0]   rptr_gray_sync
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          full_q;
  logic [PW-1:0] wbin, wbin_nx, rbin_s, occ;

  assign wr_en      = push_valid & ~full_q;
  assign push_ready = ~full_q;
  assign wr_addr    = wbin[ADDR_W-1:0];
  assign rbin_s     = g2b(rptr_gray_sync);
  assign occ        = wbin - rbin_s;

  dcf_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (wr_en),
    .bin   (wbin),
    .bin_nx(wbin_nx),
    .gray  (wptr_gray)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= (wbin_nx[PW-1] != rbin_s[PW-1]) &&
                          (wbin_nx[ADDR_W-1:0] == rbin_s[ADDR_W-1:0]);
  end

  // R3: the writer's view never exceeds capacity.
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(DEPTH));
  // R3: a view of DEPTH words always closes the write side.
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == PW'(DEPTH)) |-> !push_ready);
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
// Consumer-domain control: hands out words, registers the empty flag.
module dcf_rd_side #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              pop_valid,
  input  logic              pop_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W:0]   rptr_gray,
  input  logic [ADDR_W:0]   wptr_gray_sync
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          empty_q, rd_en;
  logic [PW-1:0] rbin, rbin_nx, wbin_s, occ;

  assign rd_en     = pop_ready & ~empty_q;
  assign pop_valid = ~empty_q;
  assign rd_addr   = rbin[ADDR_W-1:0];
  assign wbin_s    = g2b(wptr_gray_sync);
  assign occ       = wbin_s - rbin;

  dcf_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (rd_en),
    .bin   (rbin),
    .bin_nx(rbin_nx),
    .gray  (rptr_gray)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_q <= 1'b1;
    else        empty_q <= (rbin_nx == wbin_s);
  end

  // R4: the reader's view never goes below zero or above capacity.
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(DEPTH));
  // R4: a view of zero words always drops valid.
  p_empty_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !pop_valid);
endmodule

// File: rtl/dc_stream_fifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO with valid/ready streaming on both sides.
module dc_stream_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rclk,
  input  logic              rrst_n,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PW = ADDR_W + 1;

  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;

  dcf_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .clk           (wclk),
    .rst_n         (wrst_n),
    .push_valid    (wr_valid),
    .push_ready    (wr_ready),
    .wr_en         (we),
    .wr_addr       (waddr),
    .wptr_gray     (wgray),
    .rptr_gray_sync(rgray_s)
  );

  dcf_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .clk           (rclk),
    .rst_n         (rrst_n),
    .pop_valid     (rd_valid),
    .pop_ready     (rd_ready),
    .rd_addr       (raddr),
    .rptr_gray     (rgray),
    .wptr_gray_sync(wgray_s)
  );

  dcf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
  dcf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));

  dcf_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk (wclk),
    .we   (we),
    .waddr(waddr),
    .wdata(wr_data),
    .raddr(raddr),
    .rdata(rd_data)
  );

  // R6: a stalled consumer sees the same head word, still valid.
  p_head_hold_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/dc_stream_fifo_tb.sv
`timescale 1ns/1ps
module dc_stream_fifo_tb;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  logic wclk = 1'b0, rclk = 1'b0, wrst_n = 1'b0, rrst_n = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic wr_ready, rd_valid;
  logic [DATA_W-1:0] rd_data;

  always #2    wclk = ~wclk;   // 250 MHz
  always #3.65 rclk = ~rclk;   // unrelated consumer clock

  dc_stream_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rclk(rclk), .rrst_n(rrst_n), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data)
  );

  int checks = 0, fails = 0, wcyc = 0;
  int pushed = 0, popped = 0;
  logic [DATA_W-1:0] model_q[$];
  logic [DATA_W-1:0] seq = 8'h00;

  task automatic finish_sim();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Producer-side cycle: offer a word (or idle) and record the handshake.
  task automatic wr_cycle(input bit offer, output bit took);
    @(negedge wclk);
    wr_valid = offer;
    wr_data  = seq;
    #1;
    took = offer && wr_ready;
    if (wr_ready && model_q.size() >= DEPTH)
      chk(1'b0, "R3 ready while model full", model_q.size(), DEPTH - 1);
    if (took) begin
      model_q.push_back(seq);
      seq++;
      pushed++;
    end
  endtask

  // Consumer-side cycle: compare the shown head with the model.
  task automatic rd_cycle(input bit rdy, output bit took);
    @(negedge rclk);
    rd_ready = rdy;
    #1;
    took = 1'b0;
    if (rd_valid) begin
      if (model_q.size() == 0) begin
        chk(1'b0, "R4 valid with model empty", 1, 0);
      end else begin
        if (rd_data != model_q[0])
          chk(1'b0, "R5/R6 head word", rd_data, model_q[0]);
        if (rdy) begin
          chk(rd_data == model_q[0], "R5 popped word", rd_data, model_q[0]);
          void'(model_q.pop_front());
          popped++;
          took = 1'b1;
        end
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge wclk);
      wcyc++;
      if (wcyc > 150000) begin
        chk(1'b0, "watchdog all", wcyc, 150000);
        finish_sim();
      end
    end
  end

  initial begin
    bit t;
    int n;
    logic [DATA_W-1:0] held;

    // R1: reset state, during reset and after release.
    repeat (3) @(negedge wclk);
    chk(wr_ready == 1'b1, "R1 wr_ready in reset", wr_ready, 1);
    chk(rd_valid == 1'b0, "R1 rd_valid in reset", rd_valid, 0);
    wrst_n = 1'b1; rrst_n = 1'b1;
    repeat (4) @(negedge rclk);
    chk(wr_ready == 1'b1, "R1 wr_ready after reset", wr_ready, 1);
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);

    // R3: fill with the consumer stalled; exactly DEPTH writes fit.
    n = 0;
    for (int k = 0; k < DEPTH + 6; k++) begin
      wr_cycle(1'b1, t);
      if (t) n++;
    end
    chk(n == DEPTH, "R3 accepted writes", n, DEPTH);
    chk(wr_ready == 1'b0, "R3 ready low when full", wr_ready, 0);
    @(negedge wclk); wr_valid = 1'b0;

    // R6: stalled consumer sees a steady head word.
    rd_cycle(1'b0, t);
    held = rd_data;
    for (int k = 0; k < 5; k++) rd_cycle(1'b0, t);
    chk(rd_valid == 1'b1, "R6 valid held under stall", rd_valid, 1);
    chk(rd_data == held, "R6 head stable under stall", rd_data, held);
    chk(wr_ready == 1'b0, "R3 still full with no reads", wr_ready, 0);

    // R2: idle producer cycles added nothing; drain yields exactly DEPTH.
    n = 0;
    for (int k = 0; k < 40 && (k < 3 || rd_valid); k++) begin
      rd_cycle(1'b1, t);
      if (t) n++;
    end
    @(negedge rclk); rd_ready = 1'b0;
    chk(n == DEPTH, "R2 words drained", n, DEPTH);
    chk(model_q.size() == 0, "R5 model empty after drain", model_q.size(), 0);

    // R8: write side reopens within a bounded delay.
    n = 0;
    while (!wr_ready && n < 20) begin @(negedge wclk); n++; end
    chk(n <= 10, "R8 wr_ready release delay", n, 10);

    // R8: a single word into an empty FIFO becomes visible in bounded time.
    wr_cycle(1'b1, t);
    @(negedge wclk); wr_valid = 1'b0;
    n = 0;
    while (!rd_valid && n < 20) begin @(negedge rclk); n++; end
    chk(n <= 6, "R8 rd_valid rise delay", n, 6);
    rd_cycle(1'b1, t);
    chk(t == 1'b1, "R5 single word taken", t, 1);
    rd_cycle(1'b0, t);
    chk(rd_valid == 1'b0, "R4 valid drops after last word", rd_valid, 0);

    // R2/R5: random stalls on both sides, three rate mixes.
    for (int mix = 0; mix < 3; mix++) begin
      int wp, rp, target;
      wp = (mix == 0) ? 70 : (mix == 1) ? 95 : 30;
      rp = (mix == 0) ? 60 : (mix == 1) ? 25 : 95;
      target = pushed + 600;
      fork
        begin
          while (pushed < target) wr_cycle($urandom_range(99) < wp, t);
          @(negedge wclk); wr_valid = 1'b0;
        end
        begin
          while (popped < target) rd_cycle($urandom_range(99) < rp, t);
          @(negedge rclk); rd_ready = 1'b0;
        end
      join
      chk(popped == pushed, "R2 counts balance", popped, pushed);
    end

    repeat (8) @(negedge rclk);
    chk(rd_valid == 1'b0, "R4 empty at end", rd_valid, 0);
    chk(model_q.size() == 0, "R5 nothing left in model", model_q.size(), 0);
    chk(wr_ready == 1'b1, "R8 ready at end", wr_ready, 1);
    finish_sim();
  end
endmodule